// File: doc/BRIEF.md
# Controller-Filled Streaming Read Queue

This block gives a consuming datapath a plain streaming read port (a word, a not-empty flag and a pop strobe) on top of one local SRAM used as a ring buffer. Nothing inside the block pushes data. A separate filling controller owns the producer side. It reads the free-space count, writes words into the free region at offsets counted from the committed head, and then commits them by advancing the head through a command port. Only words that have been committed are visible to the consumer. Each accepted pop moves the tail forward by one.

The filler also keeps a source-address register in the block. It loads a start address and then steps that address by a programmable stride for every word the buffer accepts. A stride of one gives a sequential walk, and a larger stride gives a strided walk. A commit that claims more words than the free space allows is dropped and raises a sticky error flag. The SRAM has one cycle of read latency, so the word at the tail is fetched ahead of time into an output register. The consumer can then pop on every cycle with no bubbles.

Top module: `sw_fill_fifo`

## Requirements
- R1: After reset, appNotEmpty is 0, freeSpace equals DEPTH (16 by default), overflowErr is 0 and srcAddr is 0.
- R2: Words written with fillWrEn but not yet committed never make appNotEmpty rise and never change freeSpace.
- R3: When a commit of N words is sampled at a rising edge, freeSpace drops by N at that same edge. If the queue was empty, appNotEmpty rises at the second rising edge after the commit, and appData shows the word written at offset 0. Words leave in commit order, and offset k is the k-th word after the committed head.
- R4: A pop with appNotEmpty high removes the word shown on appData and adds one to freeSpace. While appPop is held, one word leaves on every cycle with no empty cycles between them.
- R5: freeSpace always equals DEPTH minus (committed words minus popped words), and it never exceeds DEPTH.
- R6: A commit whose count is larger than freeSpace is ignored: the head does not move and freeSpace does not drop. It sets overflowErr, and overflowErr stays at 1 until reset.
- R7: A pop while appNotEmpty is 0 is ignored: freeSpace does not change and no word is lost.
- R8: A write whose offset is not less than freeSpace is ignored: committed data is not overwritten and srcAddr does not step.
- R9: srcLoadEn loads srcAddr from srcLoadAddr. Each accepted write adds srcStride to srcAddr, so a stride of 1 gives a sequential walk. A load takes priority over a step in the same cycle.
- R10: A commit and a pop sampled at the same edge both take effect, and freeSpace changes by one minus the commit count.
- R11: Pointers wrap modulo DEPTH with one extra lap bit. A full queue that spans the end of the array drains in commit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fillWrEn | input | 1 | Filler writes one word into the buffer |
| fillWrOfs | input | AW | Write offset from the committed head |
| fillWrData | input | WIDTH | Word to write |
| headAdvEn | input | 1 | Commit strobe that advances the head |
| headAdvCount | input | AW+1 | Number of words to commit |
| freeSpace | output | AW+1 | Free entries seen by the filler |
| overflowErr | output | 1 | Sticky flag set by a rejected commit |
| srcLoadEn | input | 1 | Load the source address |
| srcLoadAddr | input | SAW | Value for the load |
| srcStride | input | SAW | Step added to the source address for each accepted word |
| srcAddr | output | SAW | Current source address |
| appNotEmpty | output | 1 | A committed word is on appData |
| appData | output | WIDTH | Oldest committed word |
| appPop | input | 1 | Consumer takes the word on appData |

## Verification
Two pairs of functions can land in the same cycle. A head commit and a consumer pop can meet at one clock edge. A filler write into the free region can also coincide with the prefetch read of the tail word. The bench provokes the first pair by driving a two-word commit and a pop into the same edge, and it judges the result by the net freeSpace change of minus one and by the order in which the scoreboard sees the words. The second pair comes up during every continuous drain that overlaps new writes. Any corrupted word shows up as a scoreboard mismatch.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;   // accepted filler write
    logic rdEn;   // fetch the next tail word into the output register
  } sfifoStrobes_t;
endpackage

// File: rtl/sfifo_srcgen.sv
module sfifo_srcgen #(
  parameter int SAW = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           loadEn,
  input  logic [SAW-1:0] loadAddr,
  input  logic [SAW-1:0] stride,
  input  logic           stepEn,
  output logic [SAW-1:0] srcAddr
);
  always_ff @(posedge clk) begin
    if (!rstN)        srcAddr <= '0;
    else if (loadEn)  srcAddr <= loadAddr;
    else if (stepEn)  srcAddr <= srcAddr + stride;
  end
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fillWrEn,
  input  logic [AW-1:0] fillWrOfs,
  input  logic          headAdvEn,
  input  logic [PW-1:0] headAdvCount,
  input  logic          appPop,
  output sfifoStrobes_t strb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          outValid,
  output logic [PW-1:0] freeSpace,
  output logic          overflowErr
);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  logic [PW-1:0] headQ, tailQ, usedCnt, rdPtr;
  logic advOk, advBad, popOk, rdAvail;

  // Pointers carry one lap bit, so full and empty stay distinct
  assign usedCnt   = headQ - tailQ;
  assign freeSpace = FULL - usedCnt;

  // Filler side
  assign strb.wrEn = fillWrEn && ({1'b0, fillWrOfs} < freeSpace);
  assign wrAddr    = headQ[AW-1:0] + fillWrOfs;
  assign advOk     = headAdvEn && (headAdvCount <= freeSpace);
  assign advBad    = headAdvEn && !advOk;

  // Consumer side: the output register holds the word at tailQ
  assign popOk     = appPop && outValid;
  assign rdPtr     = tailQ + {{AW{1'b0}}, outValid};
  assign rdAvail   = rdPtr != headQ;
  assign strb.rdEn = rdAvail && (!outValid || appPop);
  assign rdAddr    = rdPtr[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ       <= '0;
      tailQ       <= '0;
      outValid    <= 1'b0;
      overflowErr <= 1'b0;
    end else begin
      if (advOk) headQ <= headQ + headAdvCount;
      if (popOk) tailQ <= tailQ + PW'(1);
      if (strb.rdEn)  outValid <= 1'b1;
      else if (popOk) outValid <= 1'b0;
      if (advBad) overflowErr <= 1'b1;
    end
  end
endmodule

// File: rtl/sfifo_dpath.sv
module sfifo_dpath
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  sfifoStrobes_t    strb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [AW-1:0]    rdAddr,
  output logic [WIDTH-1:0] outData
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Writes only reach the free region, so they never alias a fetch
  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[wrAddr] <= wrData;
  end

  // One-cycle SRAM read lands directly in the output register
  always_ff @(posedge clk) begin
    if (!rstN)          outData <= '0;
    else if (strb.rdEn) outData <= mem[rdAddr];
  end
endmodule

// File: rtl/sw_fill_fifo.sv
module sw_fill_fifo
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  parameter int SAW   = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fillWrEn,
  input  logic [AW-1:0]    fillWrOfs,
  input  logic [WIDTH-1:0] fillWrData,
  input  logic             headAdvEn,
  input  logic [PW-1:0]    headAdvCount,
  output logic [PW-1:0]    freeSpace,
  output logic             overflowErr,
  input  logic             srcLoadEn,
  input  logic [SAW-1:0]   srcLoadAddr,
  input  logic [SAW-1:0]   srcStride,
  output logic [SAW-1:0]   srcAddr,
  output logic             appNotEmpty,
  output logic [WIDTH-1:0] appData,
  input  logic             appPop
);
  sfifoStrobes_t strb;
  logic [AW-1:0] wrAddr, rdAddr;

  sfifo_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN),
    .fillWrEn(fillWrEn), .fillWrOfs(fillWrOfs),
    .headAdvEn(headAdvEn), .headAdvCount(headAdvCount),
    .appPop(appPop), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .outValid(appNotEmpty), .freeSpace(freeSpace),
    .overflowErr(overflowErr)
  );

  sfifo_dpath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .wrData(fillWrData),
    .rdAddr(rdAddr), .outData(appData)
  );

  sfifo_srcgen #(.SAW(SAW)) uSrc (
    .clk(clk), .rstN(rstN),
    .loadEn(srcLoadEn), .loadAddr(srcLoadAddr),
    .stride(srcStride), .stepEn(strb.wrEn),
    .srcAddr(srcAddr)
  );
endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  parameter int SAW   = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             fillWrEn,
  input logic [AW-1:0]    fillWrOfs,
  input logic             headAdvEn,
  input logic [PW-1:0]    headAdvCount,
  input logic [PW-1:0]    freeSpace,
  input logic             overflowErr,
  input logic             srcLoadEn,
  input logic [SAW-1:0]   srcLoadAddr,
  input logic [SAW-1:0]   srcStride,
  input logic [SAW-1:0]   srcAddr,
  input logic             appNotEmpty,
  input logic [WIDTH-1:0] appData,
  input logic             appPop
);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  a_r5_free_bound: assert property (@(posedge clk) disable iff (!rstN)
    freeSpace <= FULL);

  a_r2_empty_hidden: assert property (@(posedge clk) disable iff (!rstN)
    (freeSpace == FULL) |-> !appNotEmpty);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> overflowErr);

  a_r6_reject: assert property (@(posedge clk) disable iff (!rstN)
    (headAdvEn && headAdvCount > freeSpace) |=>
      (overflowErr && freeSpace == $past(freeSpace) + PW'($past(appPop && appNotEmpty))));

  a_r7_idle_pop: assert property (@(posedge clk) disable iff (!rstN)
    (appPop && !appNotEmpty && !headAdvEn) |=> freeSpace == $past(freeSpace));

  a_r4_pop_frees: assert property (@(posedge clk) disable iff (!rstN)
    (appPop && appNotEmpty && !headAdvEn) |=> freeSpace == $past(freeSpace) + PW'(1));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (appNotEmpty && !appPop) |=> (appNotEmpty && $stable(appData)));

  a_r9_step: assert property (@(posedge clk) disable iff (!rstN)
    (fillWrEn && ({1'b0, fillWrOfs} < freeSpace) && !srcLoadEn) |=>
      srcAddr == $past(srcAddr + srcStride));

  a_r9_load: assert property (@(posedge clk) disable iff (!rstN)
    srcLoadEn |=> srcAddr == $past(srcLoadAddr));
endmodule

bind sw_fill_fifo sfifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .SAW(SAW)) uChk (.*);

// File: tb/sim_sw_fill_fifo.sv
module sim_sw_fill_fifo;
  localparam int DEPTH = 16;
  localparam int WIDTH = 32;
  localparam int SAW   = 32;
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic clk = 0, rstN = 0;
  logic fillWrEn = 0, headAdvEn = 0, srcLoadEn = 0, appPop = 0;
  logic [AW-1:0] fillWrOfs = '0;
  logic [WIDTH-1:0] fillWrData = '0;
  logic [PW-1:0] headAdvCount = '0;
  logic [SAW-1:0] srcLoadAddr = '0, srcStride = 32'd1;
  logic [PW-1:0] freeSpace;
  logic overflowErr, appNotEmpty;
  logic [SAW-1:0] srcAddr;
  logic [WIDTH-1:0] appData;

  int total = 0, bad = 0;
  logic popEnable = 0;
  string curReq = "R4";
  logic [WIDTH-1:0] pendQ[$];
  logic [WIDTH-1:0] expQ[$];

  always #4 clk = ~clk;

  sw_fill_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .SAW(SAW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  // Monitor: drives the pop and scores each popped word
  always @(negedge clk) begin
    appPop = popEnable;
    if (appPop && appNotEmpty) begin
      if (expQ.size() == 0) chk(0, curReq, appData, 32'h0);
      else begin
        logic [WIDTH-1:0] e;
        e = expQ.pop_front();
        chk(appData == e, curReq, appData, e);
      end
    end
  end

  task automatic writeWords(input int n, input logic [WIDTH-1:0] base);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      fillWrEn = 1; fillWrOfs = AW'(pendQ.size()); fillWrData = base + WIDTH'(i);
      pendQ.push_back(base + WIDTH'(i));
    end
    @(posedge clk); #2; fillWrEn = 0;
  endtask

  task automatic commit(input int n);
    @(posedge clk); #2;
    headAdvEn = 1; headAdvCount = PW'(n);
    for (int i = 0; i < n && pendQ.size() > 0; i++) expQ.push_back(pendQ.pop_front());
    @(posedge clk); #2; headAdvEn = 0;
  endtask

  task automatic drain(input string req);
    int k, n;
    k = expQ.size(); n = 0;
    curReq = req;
    @(posedge clk); #2; popEnable = 1;
    while (expQ.size() > 0 && n < 100) begin
      @(negedge clk); #1; n++;
    end
    popEnable = 0;
    chk(n == k, req, n, k);  // one word per cycle, no bubbles
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(appNotEmpty == 0, "R1", appNotEmpty, 0);
    chk(freeSpace == 16, "R1", freeSpace, 16);
    chk(overflowErr == 0, "R1", overflowErr, 0);
    chk(srcAddr == 0, "R1", srcAddr, 0);

    // R9 load then stride 4
    @(posedge clk); #2; srcLoadEn = 1; srcLoadAddr = 32'h100; srcStride = 32'd4;
    @(posedge clk); #2; srcLoadEn = 0;
    writeWords(3, 32'hA000);
    @(negedge clk);
    chk(srcAddr == 32'h10C, "R9", srcAddr, 32'h10C);

    // R2 uncommitted words hidden
    repeat (3) @(negedge clk);
    chk(appNotEmpty == 0, "R2", appNotEmpty, 0);
    chk(freeSpace == 16, "R2", freeSpace, 16);

    // R3 commit timing and first word
    commit(3);
    @(negedge clk);
    chk(appNotEmpty == 0, "R3", appNotEmpty, 0);
    chk(freeSpace == 13, "R5", freeSpace, 13);
    @(negedge clk);
    chk(appNotEmpty == 1, "R3", appNotEmpty, 1);
    chk(appData == 32'hA000, "R3", appData, 32'hA000);

    // R4 back-to-back drain
    drain("R4");
    repeat (2) @(negedge clk);
    chk(appNotEmpty == 0, "R4", appNotEmpty, 0);
    chk(freeSpace == 16, "R4", freeSpace, 16);

    // R7 pops on empty ignored
    @(posedge clk); #2; popEnable = 1;
    repeat (3) @(posedge clk);
    #2 popEnable = 0;
    @(negedge clk);
    chk(freeSpace == 16, "R7", freeSpace, 16);
    chk(appNotEmpty == 0, "R7", appNotEmpty, 0);

    // R11 full buffer that wraps (head starts at 3)
    writeWords(16, 32'hB000);
    commit(16);
    repeat (2) @(negedge clk);
    chk(freeSpace == 0, "R5", freeSpace, 0);
    chk(appData == 32'hB000, "R11", appData, 32'hB000);

    // R8 write outside free region ignored
    @(posedge clk); #2; fillWrEn = 1; fillWrOfs = '0; fillWrData = 32'hDEAD;
    @(posedge clk); #2; fillWrEn = 0;
    @(negedge clk);
    chk(srcAddr == 32'h14C, "R8", srcAddr, 32'h14C);

    // R6 overflowing commit
    commit(1);
    @(negedge clk);
    chk(overflowErr == 1, "R6", overflowErr, 1);
    chk(freeSpace == 0, "R6", freeSpace, 0);
    drain("R11");
    repeat (2) @(negedge clk);
    chk(freeSpace == 16, "R11", freeSpace, 16);

    // R10 commit and pop at the same edge
    writeWords(6, 32'hC000);
    commit(4);
    repeat (3) @(negedge clk);
    chk(freeSpace == 12, "R10", freeSpace, 12);
    curReq = "R10";
    @(posedge clk); #2;
    headAdvEn = 1; headAdvCount = PW'(2); popEnable = 1;
    for (int i = 0; i < 2; i++) expQ.push_back(pendQ.pop_front());
    @(posedge clk); #2; headAdvEn = 0; popEnable = 0;
    @(negedge clk); #1;
    chk(freeSpace == 11, "R10", freeSpace, 11);
    drain("R10");
    repeat (2) @(negedge clk);
    chk(freeSpace == 16, "R10", freeSpace, 16);
    chk(overflowErr == 1, "R6", overflowErr, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule